// File: doc/BRIEF.md
# Static Not-Taken Branch Resolver

This block settles conditional and unconditional branches for a short in-order pipeline whose fetch stage always assumes a branch falls through and keeps stepping the program counter by one. When a branch reaches the stage where its outcome is known, the pipeline pulses a resolve strobe. With that strobe come the branch kind, the precomputed target (the PC plus a long offset, formed upstream) and the current negative and zero status flags.

A branch that turns out taken is a misprediction. On the cycle after the strobe, the block drives the PC multiplexer to the target, loads the PC with it, and raises a flush line for every pipeline buffer so that the younger instructions become bubbles. A branch that falls through leaves the pipeline alone. A trap flush has priority: a strobe that arrives while a trap flush is active is dropped. Two free-running counters record accepted resolves and mispredictions so that a model can compare against them.

Top module: `brResolver`

## Requirements
- R1: While reset is held and on the first cycle after it, pcSel, pcLoad and every flushVec bit are 0, and both counters read 0.
- R2: Branch kind 2'b00 (on negative) is taken exactly when flagN is 1 at the strobe.
- R3: Branch kind 2'b01 (on zero) is taken exactly when flagZ is 1 at the strobe.
- R4: Branch kind 2'b10 (always) is taken whatever the flags are.
- R5: Branch kind 2'b11 is never taken.
- R6: For a taken branch, pcSel and pcLoad are 1 on the cycle after the strobe, for that one cycle only, and pcTarget then equals the branchTarget that was sampled with the strobe.
- R7: For a taken branch, every bit of flushVec is 1 in the same cycle as pcLoad.
- R8: For a branch that is not taken, pcSel, pcLoad and flushVec stay 0.
- R9: A strobe that coincides with trapFlush causes no redirect and no flush, and neither counter moves.
- R10: resolvedCnt grows by one, one cycle after each strobe that is accepted (strobe present and no trap flush), and wraps at its width.
- R11: mispredictCnt grows by one, one cycle after each taken branch.
- R12: With no strobe, the flags, the kind and the target have no effect: no redirect, no flush, and the counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resolveValid | input | 1 | A branch is resolving this cycle |
| branchType | input | 2 | Branch kind: 00 on N, 01 on Z, 10 always, 11 never |
| branchTarget | input | ADDR_W | Precomputed branch target address |
| flagN | input | 1 | Negative status flag |
| flagZ | input | 1 | Zero status flag |
| trapFlush | input | 1 | A trap flush is in progress and takes priority |
| pcSel | output | 1 | PC multiplexer chooses the target instead of PC+1 |
| pcLoad | output | 1 | Load the PC from the multiplexer |
| pcTarget | output | ADDR_W | Redirect address, valid while pcLoad is 1 |
| flushVec | output | NUM_BUFS | One flush line per pipeline buffer, which clears its valid bit |
| resolvedCnt | output | CNT_W | Count of accepted resolves |
| mispredictCnt | output | CNT_W | Count of taken (mispredicted) branches |

## Verification
Every output is registered once. A strobe given before a rising edge therefore produces the redirect, the flush and the counter increments after that same edge, with no further delay. The bench drives inputs on the falling edge and advances its model on the rising edge. It compares every output with the model on the next falling edge, which is the one cycle on which a redirect pulse is visible. The directed branch cases also check pcLoad at exactly that falling edge, and they check that it has dropped again one cycle later.

// File: rtl/brResolverPkg.sv
package brResolverPkg;

  typedef enum logic [1:0] {
    BR_ON_NEG  = 2'b00,
    BR_ON_ZERO = 2'b01,
    BR_ALWAYS  = 2'b10,
    BR_NEVER   = 2'b11
  } brKind_t;

  typedef struct packed {
    logic accept;
    logic redirect;
  } brStrobe_t;

endpackage

// File: rtl/brResolverCtrl.sv
module brResolverCtrl
  import brResolverPkg::*;
(
  input  logic       resolveValid,
  input  logic [1:0] branchType,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       trapFlush,
  output brStrobe_t  strobe
);

  logic condMet;

  always_comb begin
    unique case (brKind_t'(branchType))
      BR_ON_NEG:  condMet = flagN;
      BR_ON_ZERO: condMet = flagZ;
      BR_ALWAYS:  condMet = 1'b1;
      default:    condMet = 1'b0;
    endcase
  end

  always_comb begin
    strobe.accept   = resolveValid && !trapFlush;
    strobe.redirect = strobe.accept && condMet;
  end

endmodule

// File: rtl/brResolverDatapath.sv
module brResolverDatapath
  import brResolverPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_BUFS = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  brStrobe_t           strobe,
  input  logic [ADDR_W-1:0]   branchTarget,
  output logic                pcSel,
  output logic                pcLoad,
  output logic [ADDR_W-1:0]   pcTarget,
  output logic [NUM_BUFS-1:0] flushVec,
  output logic [CNT_W-1:0]    resolvedCnt,
  output logic [CNT_W-1:0]    mispredictCnt
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcSel    <= 1'b0;
      pcLoad   <= 1'b0;
      pcTarget <= '0;
    end else begin
      pcSel  <= strobe.redirect;
      pcLoad <= strobe.redirect;
      if (strobe.redirect) pcTarget <= branchTarget;
    end
  end

  for (genvar b = 0; b < NUM_BUFS; b++) begin : gFlush
    always_ff @(posedge clk) begin
      if (!rstN) flushVec[b] <= 1'b0;
      else       flushVec[b] <= strobe.redirect;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resolvedCnt   <= '0;
      mispredictCnt <= '0;
    end else begin
      if (strobe.accept)   resolvedCnt   <= resolvedCnt + CNT_ONE;
      if (strobe.redirect) mispredictCnt <= mispredictCnt + CNT_ONE;
    end
  end

endmodule

// File: rtl/brResolver.sv
module brResolver
  import brResolverPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_BUFS = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                resolveValid,
  input  logic [1:0]          branchType,
  input  logic [ADDR_W-1:0]   branchTarget,
  input  logic                flagN,
  input  logic                flagZ,
  input  logic                trapFlush,
  output logic                pcSel,
  output logic                pcLoad,
  output logic [ADDR_W-1:0]   pcTarget,
  output logic [NUM_BUFS-1:0] flushVec,
  output logic [CNT_W-1:0]    resolvedCnt,
  output logic [CNT_W-1:0]    mispredictCnt
);

  brStrobe_t strobe;

  brResolverCtrl ctrl_i (
    .resolveValid (resolveValid),
    .branchType   (branchType),
    .flagN        (flagN),
    .flagZ        (flagZ),
    .trapFlush    (trapFlush),
    .strobe       (strobe)
  );

  brResolverDatapath #(
    .ADDR_W   (ADDR_W),
    .NUM_BUFS (NUM_BUFS),
    .CNT_W    (CNT_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .branchTarget  (branchTarget),
    .pcSel         (pcSel),
    .pcLoad        (pcLoad),
    .pcTarget      (pcTarget),
    .flushVec      (flushVec),
    .resolvedCnt   (resolvedCnt),
    .mispredictCnt (mispredictCnt)
  );

endmodule

// File: rtl/brResolverChk.sv
module brResolverChk #(
  parameter int ADDR_W   = 16,
  parameter int NUM_BUFS = 4,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                resolveValid,
  input logic [1:0]          branchType,
  input logic [ADDR_W-1:0]   branchTarget,
  input logic                flagN,
  input logic                flagZ,
  input logic                trapFlush,
  input logic                pcSel,
  input logic                pcLoad,
  input logic [ADDR_W-1:0]   pcTarget,
  input logic [NUM_BUFS-1:0] flushVec,
  input logic [CNT_W-1:0]    resolvedCnt,
  input logic [CNT_W-1:0]    mispredictCnt
);

  logic acc;
  assign acc = resolveValid && !trapFlush;

  AST_NEG_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (acc && branchType == 2'b00) |=> (pcLoad == $past(flagN))); // R2

  AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (acc && branchType == 2'b01) |=> (pcLoad == $past(flagZ))); // R3

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (acc && branchType == 2'b10) |=> pcLoad); // R4

  AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && branchType == 2'b11) |=> !pcLoad); // R5

  AST_TARGET_SEL: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (pcSel && pcTarget == $past(branchTarget))); // R6

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (&flushVec)); // R7

  AST_NO_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pcLoad |-> (flushVec == '0 && !pcSel)); // R8

  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    trapFlush |=> (!pcLoad && $stable(resolvedCnt) && $stable(mispredictCnt))); // R9

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |=> (!pcLoad && $stable(resolvedCnt))); // R12

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (mispredictCnt == $past(mispredictCnt) + CNT_W'(1))); // R11

endmodule

bind brResolver brResolverChk #(
  .ADDR_W   (ADDR_W),
  .NUM_BUFS (NUM_BUFS),
  .CNT_W    (CNT_W)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .resolveValid  (resolveValid),
  .branchType    (branchType),
  .branchTarget  (branchTarget),
  .flagN         (flagN),
  .flagZ         (flagZ),
  .trapFlush     (trapFlush),
  .pcSel         (pcSel),
  .pcLoad        (pcLoad),
  .pcTarget      (pcTarget),
  .flushVec      (flushVec),
  .resolvedCnt   (resolvedCnt),
  .mispredictCnt (mispredictCnt)
);

// File: tb/brResolver_tb_top.sv
module brResolver_tb_top;

  localparam int ADDR_W   = 16;
  localparam int NUM_BUFS = 4;
  localparam int CNT_W    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resolveValid = 1'b0;
  logic [1:0] branchType = 2'b00;
  logic [ADDR_W-1:0] branchTarget = '0;
  logic flagN = 1'b0, flagZ = 1'b0, trapFlush = 1'b0;
  logic pcSel, pcLoad;
  logic [ADDR_W-1:0] pcTarget;
  logic [NUM_BUFS-1:0] flushVec;
  logic [CNT_W-1:0] resolvedCnt, mispredictCnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brResolver #(.ADDR_W(ADDR_W), .NUM_BUFS(NUM_BUFS), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .resolveValid(resolveValid), .branchType(branchType),
    .branchTarget(branchTarget), .flagN(flagN), .flagZ(flagZ), .trapFlush(trapFlush),
    .pcSel(pcSel), .pcLoad(pcLoad), .pcTarget(pcTarget), .flushVec(flushVec),
    .resolvedCnt(resolvedCnt), .mispredictCnt(mispredictCnt)
  );

  // Behavioural reference model
  bit mLoad = 0;
  int mTarget = 0;
  int mResolved = 0;
  int mMiss = 0;

  function automatic bit takenOf(int kind, bit n, bit z);
    if (kind == 0) return n;
    if (kind == 1) return z;
    if (kind == 2) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLoad = 0; mTarget = 0; mResolved = 0; mMiss = 0;
    end else if (resolveValid && !trapFlush) begin
      mResolved = (mResolved + 1) % (1 << CNT_W);
      mLoad = takenOf(int'(branchType), flagN, flagZ);
      if (mLoad) begin
        mTarget = int'(branchTarget);
        mMiss = (mMiss + 1) % (1 << CNT_W);
      end
    end else begin
      mLoad = 0;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(pcLoad == mLoad, "R6 pcLoad", int'(pcLoad), int'(mLoad));
      check(pcSel == mLoad, "R6 pcSel", int'(pcSel), int'(mLoad));
      check(flushVec == (mLoad ? {NUM_BUFS{1'b1}} : '0), "R7/R8 flushVec",
            int'(flushVec), mLoad ? (1 << NUM_BUFS) - 1 : 0);
      if (mLoad) check(int'(pcTarget) == mTarget, "R6 pcTarget", int'(pcTarget), mTarget);
      check(int'(resolvedCnt) == mResolved, "R10 resolvedCnt", int'(resolvedCnt), mResolved);
      check(int'(mispredictCnt) == mMiss, "R11 mispredictCnt", int'(mispredictCnt), mMiss);
    end
  end

  task automatic resolveOne(int kind, bit n, bit z, bit trap, int tgt, bit expTaken, string req);
    @(negedge clk);
    resolveValid = 1'b1; branchType = 2'(kind); flagN = n; flagZ = z;
    trapFlush = trap; branchTarget = ADDR_W'(tgt);
    @(negedge clk);
    resolveValid = 1'b0; trapFlush = 1'b0;
    check(pcLoad == expTaken, req, int'(pcLoad), int'(expTaken));
    @(negedge clk);
    check(pcLoad == 1'b0, {req, " pulse ends"}, int'(pcLoad), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check(pcLoad == 0 && pcSel == 0 && flushVec == '0, "R1 outputs in reset", int'(flushVec), 0);
    check(resolvedCnt == 0 && mispredictCnt == 0, "R1 counters in reset", int'(resolvedCnt), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pcLoad == 0 && flushVec == '0, "R1 after reset", int'(pcLoad), 0);

    resolveOne(0, 1, 0, 0, 16'h1234, 1, "R2 neg taken");
    resolveOne(0, 0, 1, 0, 16'h2222, 0, "R2 neg not taken");
    resolveOne(1, 0, 1, 0, 16'h3456, 1, "R3 zero taken");
    resolveOne(1, 1, 0, 0, 16'h4444, 0, "R3 zero not taken");
    resolveOne(2, 0, 0, 0, 16'hABCD, 1, "R4 always flags clear");
    resolveOne(2, 1, 1, 0, 16'h0F0F, 1, "R4 always flags set");
    resolveOne(3, 1, 1, 0, 16'h5555, 0, "R5 never");
    resolveOne(2, 1, 1, 1, 16'h7777, 0, "R9 trap wins");
    check(int'(mispredictCnt) == 4, "R11 miss count after directed", int'(mispredictCnt), 4);
    check(int'(resolvedCnt) == 7, "R10 resolved count (trap excluded)", int'(resolvedCnt), 7);

    // R12: inputs wiggle without a strobe
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      branchType = 2'b10; flagN = i[0]; flagZ = i[1]; branchTarget = ADDR_W'(i * 97);
    end
    @(negedge clk);
    check(pcLoad == 0 && flushVec == '0, "R12 no strobe", int'(pcLoad), 0);
    check(int'(resolvedCnt) == 7, "R12 counter holds", int'(resolvedCnt), 7);

    // Back-to-back taken branches and random traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      resolveValid = ($urandom % 3) != 0;
      branchType   = 2'($urandom);
      flagN        = 1'($urandom);
      flagZ        = 1'($urandom);
      trapFlush    = ($urandom % 8) == 0;
      branchTarget = ADDR_W'($urandom);
    end
    @(negedge clk);
    resolveValid = 1'b0; trapFlush = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule